// File: doc/BRIEF.md
# Next Program Counter and Return Stack Sequencer

This block works out where an 8-bit microcontroller with a 16-bit code space fetches next. The decode stage gives it the current instruction's address and length, the opcode's top three bits, the two operand bytes, a branch-kind code, the accumulator and the data pointer. The block forms the fall-through address, or a relative, page-absolute, long or indexed target. It presents the result on `npc` with a one-cycle `npc_valid` strobe.

Calls and returns also use a byte-wide stack kept in external RAM. The stack grows toward higher addresses. A call writes the return address in two cycles, low byte first. A return reads it back in two cycles, high byte first. `busy` is high during these stack cycles, and any new request that arrives then is dropped. Fetch, decode, condition evaluation and the stack RAM itself sit outside the block.

Top module: `pc_next_unit`

## Requirements
- R1: After reset `npc_valid`, `busy`, `stk_we` and `stk_re` are low, and `sp_out` equals the parameter `SP_INIT`, which defaults to 8'h07.
- R2: Branch-kind codes are: 0 sequential, 1 relative, 2 page-absolute, 3 long, 4 indexed, 5 return, with 6 and 7 treated as sequential. The fall-through address is `pc + ilen`, modulo 65536. A `start` pulse in idle with `is_call` low and a kind other than 5 puts the computed target on `npc`, with `npc_valid` high for exactly the following cycle. For kind 0 that target is the fall-through address.
- R3: A relative target is the fall-through address plus the sign-extended 8-bit offset, modulo 65536. The offset is `byte3` when `ilen` is 3 and `byte2` otherwise.
- R4: A page-absolute target keeps bits 15..11 of the fall-through address and takes bits 10..8 from `op_page` and bits 7..0 from `byte2`.
- R5: A long target is `{byte2, byte3}`.
- R6: An indexed target is `dptr` plus the zero-extended `acc`, modulo 65536.
- R7: A `start` with `is_call` high and a kind other than 5 runs two write cycles. The first writes the fall-through low byte to `sp+1`. The second writes the high byte to `sp+2`. `sp_out` rises by one after each write. The call target then appears on `npc` with `npc_valid`.
- R8: A `start` with kind 5 runs two read cycles. The first reads address `sp` and takes that byte as the high byte. The second reads `sp-1` and takes it as the low byte. `sp_out` falls by one after each read. `{high, low}` then appears on `npc` with `npc_valid`.
- R9: While `busy` is high, `start` is ignored. It starts no request, changes neither the target nor the stack traffic of the sequence in progress, and gives no extra `npc_valid` pulse.
- R10: `sp_out` and the stack addresses wrap modulo 256, so a push from 8'hFF writes addresses 8'h00 and 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request: compute next PC for the presented instruction |
| kind | input | 3 | Branch-kind code (see R2) |
| is_call | input | 1 | Push the fall-through address before branching |
| pc | input | 16 | Address of the current instruction |
| ilen | input | 2 | Instruction length in bytes |
| op_page | input | 3 | Opcode bits 7..5 |
| byte2 | input | 8 | Second instruction byte |
| byte3 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| stk_rdata | input | 8 | Stack RAM read data (combinational read) |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 8 | Stack RAM address |
| stk_wdata | output | 8 | Stack write data |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | Stack sequence in progress |
| npc | output | 16 | Next program counter |
| npc_valid | output | 1 | One-cycle strobe: `npc` updated |

## Verification
The relative mode is tried with a forward and a backward offset from a two-byte instruction, and with a three-byte instruction whose second byte is a decoy. The decoy shows whether the offset comes from the last byte and whether the base is the fall-through address and not `pc`. The page-absolute mode is tried once inside a page and once with an instruction that ends on a 2K boundary, which shows whether the upper five bits come from the advanced PC. The fall-through, relative and indexed sums are each pushed past 16'hFFFF to expose carries that are not dropped. Calls and returns are checked byte by byte on the stack port, and a long chain of calls drives the pointer through 8'hFF to 8'h00.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter logic [7:0] SP_INIT = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  kind,
  input  logic        is_call,
  input  logic [15:0] pc,
  input  logic [1:0]  ilen,
  input  logic [2:0]  op_page,
  input  logic [7:0]  byte2,
  input  logic [7:0]  byte3,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic [7:0]  stk_rdata,
  output logic        stk_we,
  output logic        stk_re,
  output logic [7:0]  stk_addr,
  output logic [7:0]  stk_wdata,
  output logic [7:0]  sp_out,
  output logic        busy,
  output logic [15:0] npc,
  output logic        npc_valid
);

  typedef enum logic [2:0] {S_IDLE, S_PUSH_LO, S_PUSH_HI, S_POP_HI, S_POP_LO} state_t;

  localparam logic [2:0] K_REL  = 3'd1;
  localparam logic [2:0] K_ABS  = 3'd2;
  localparam logic [2:0] K_LONG = 3'd3;
  localparam logic [2:0] K_IDX  = 3'd4;
  localparam logic [2:0] K_RET  = 3'd5;

  state_t      state;
  logic [7:0]  sp;
  logic [15:0] ret_q, tgt_q;
  logic [7:0]  hi_q;
  logic [15:0] fall, target;
  logic [7:0]  off;

  assign fall = pc + {14'd0, ilen};
  assign off  = (ilen == 2'd3) ? byte3 : byte2;

  always_comb begin
    case (kind)
      K_REL:   target = fall + {{8{off[7]}}, off};
      K_ABS:   target = {fall[15:11], op_page, byte2};
      K_LONG:  target = {byte2, byte3};
      K_IDX:   target = dptr + {8'd0, acc};
      default: target = fall;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sp        <= SP_INIT;
      ret_q     <= '0;
      tgt_q     <= '0;
      hi_q      <= '0;
      npc       <= '0;
      npc_valid <= 1'b0;
    end else begin
      npc_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (kind == K_RET) state <= S_POP_HI;
          else if (is_call) begin
            ret_q <= fall;
            tgt_q <= target;
            state <= S_PUSH_LO;
          end else begin
            npc       <= target;
            npc_valid <= 1'b1;
          end
        end
        S_PUSH_LO: begin
          sp    <= sp + 8'd1;
          state <= S_PUSH_HI;
        end
        S_PUSH_HI: begin
          sp        <= sp + 8'd1;
          npc       <= tgt_q;
          npc_valid <= 1'b1;
          state     <= S_IDLE;
        end
        S_POP_HI: begin
          hi_q  <= stk_rdata;
          sp    <= sp - 8'd1;
          state <= S_POP_LO;
        end
        S_POP_LO: begin
          npc       <= {hi_q, stk_rdata};
          npc_valid <= 1'b1;
          sp        <= sp - 8'd1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign stk_we    = (state == S_PUSH_LO) || (state == S_PUSH_HI);
  assign stk_re    = (state == S_POP_HI) || (state == S_POP_LO);
  assign stk_addr  = stk_we ? sp + 8'd1 : sp;
  assign stk_wdata = (state == S_PUSH_LO) ? ret_q[7:0] : ret_q[15:8];
  assign sp_out    = sp;
  assign busy      = (state != S_IDLE);

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |=> sp_out == $past(sp_out) + 8'd1); // R7
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re |=> sp_out == $past(sp_out) - 8'd1); // R8
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re)); // R8
  AST_SP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_we && !stk_re) |=> $stable(sp_out)); // R9
  AST_DONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> npc_valid); // R7
  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && !$past(stk_we)) |=> stk_we); // R7

endmodule

// File: tb/pc_next_unit_tb.sv
module pc_next_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic        is_call = 1'b0;
  logic [15:0] pc = '0;
  logic [1:0]  ilen = 2'd1;
  logic [2:0]  op_page = '0;
  logic [7:0]  byte2 = '0, byte3 = '0, acc = '0;
  logic [15:0] dptr = '0;
  logic [7:0]  stk_rdata;
  logic        stk_we, stk_re, busy, npc_valid;
  logic [7:0]  stk_addr, stk_wdata, sp_out;
  logic [15:0] npc;

  logic [7:0] mem [256];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign stk_rdata = mem[stk_addr];
  always @(posedge clk) if (stk_we) mem[stk_addr] <= stk_wdata;

  pc_next_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .is_call(is_call),
    .pc(pc), .ilen(ilen), .op_page(op_page), .byte2(byte2), .byte3(byte3),
    .acc(acc), .dptr(dptr), .stk_rdata(stk_rdata), .stk_we(stk_we),
    .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .sp_out(sp_out), .busy(busy), .npc(npc), .npc_valid(npc_valid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] k, logic c, logic [15:0] p, logic [1:0] l,
                       logic [2:0] op, logic [7:0] b2, logic [7:0] b3);
    @(negedge clk);
    kind = k; is_call = c; pc = p; ilen = l; op_page = op; byte2 = b2; byte3 = b3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic plain(string req, logic [2:0] k, logic [15:0] p, logic [1:0] l,
                       logic [2:0] op, logic [7:0] b2, logic [7:0] b3, logic [15:0] exp);
    issue(k, 1'b0, p, l, op, b2, b3);
    chk(req, {15'd0, npc_valid}, 32'd1);
    chk(req, {16'd0, npc}, {16'd0, exp});
    @(negedge clk);
    chk(req, {15'd0, npc_valid}, 32'd0);
  endtask

  task automatic do_call(string req, logic [2:0] k, logic [15:0] p, logic [1:0] l,
                         logic [7:0] b2, logic [7:0] b3, logic [15:0] exp_tgt, bit quiet);
    logic [7:0]  sp0;
    logic [15:0] ra;
    sp0 = sp_out;
    ra  = p + {14'd0, l};
    issue(k, 1'b1, p, l, 3'd0, b2, b3);
    if (!quiet) begin
      chk(req, {22'd0, busy, stk_we, stk_addr}, {22'd0, 1'b1, 1'b1, sp0 + 8'd1});
      chk(req, {24'd0, stk_wdata}, {24'd0, ra[7:0]});
    end
    @(negedge clk);
    if (!quiet) begin
      chk(req, {23'd0, stk_we, stk_addr}, {23'd0, 1'b1, sp0 + 8'd2});
      chk(req, {24'd0, stk_wdata}, {24'd0, ra[15:8]});
    end
    @(negedge clk);
    if (!quiet) begin
      chk(req, {15'd0, npc_valid}, 32'd1);
      chk(req, {16'd0, npc}, {16'd0, exp_tgt});
      chk(req, {24'd0, sp_out}, {24'd0, sp0 + 8'd2});
    end
  endtask

  task automatic do_ret(string req, logic [15:0] exp_pc);
    logic [7:0] sp0;
    sp0 = sp_out;
    issue(3'd5, 1'b0, 16'h0, 2'd1, 3'd0, 8'h0, 8'h0);
    chk(req, {23'd0, stk_re, stk_addr}, {23'd0, 1'b1, sp0});
    @(negedge clk);
    chk(req, {23'd0, stk_re, stk_addr}, {23'd0, 1'b1, sp0 - 8'd1});
    @(negedge clk);
    chk(req, {15'd0, npc_valid}, 32'd1);
    chk(req, {16'd0, npc}, {16'd0, exp_pc});
    chk(req, {24'd0, sp_out}, {24'd0, sp0 - 8'd2});
  endtask

  task automatic t_reset;
    chk("R1", {28'd0, npc_valid, busy, stk_we, stk_re}, 32'd0);
    chk("R1", {24'd0, sp_out}, 32'h07);
  endtask

  task automatic t_seq;
    plain("R2", 3'd0, 16'h1234, 2'd1, 3'd0, 8'h00, 8'h00, 16'h1235);
    plain("R2", 3'd6, 16'hFFFF, 2'd3, 3'd0, 8'h00, 8'h00, 16'h0002);
  endtask

  task automatic t_rel;
    plain("R3", 3'd1, 16'h0100, 2'd2, 3'd0, 8'h10, 8'h99, 16'h0112);
    plain("R3", 3'd1, 16'h0100, 2'd2, 3'd0, 8'hF6, 8'h00, 16'h00F8);
    plain("R3", 3'd1, 16'h0200, 2'd3, 3'd0, 8'h55, 8'h05, 16'h0208);
    plain("R3", 3'd1, 16'hFFFE, 2'd2, 3'd0, 8'h7F, 8'h00, 16'h007F);
  endtask

  task automatic t_abs;
    plain("R4", 3'd2, 16'h1000, 2'd2, 3'b111, 8'hA6, 8'h00, 16'h17A6);
    plain("R4", 3'd2, 16'h17FF, 2'd2, 3'b001, 8'h20, 8'h00, 16'h1920);
  endtask

  task automatic t_long;
    plain("R5", 3'd3, 16'h0040, 2'd3, 3'd0, 8'h8A, 8'hF2, 16'h8AF2);
  endtask

  task automatic t_idx;
    dptr = 16'h1000; acc = 8'h80;
    plain("R6", 3'd4, 16'h0000, 2'd1, 3'd0, 8'h00, 8'h00, 16'h1080);
    dptr = 16'hFFF0; acc = 8'h20;
    plain("R6", 3'd4, 16'h0000, 2'd1, 3'd0, 8'h00, 8'h00, 16'h0010);
  endtask

  task automatic t_call_ret;
    do_call("R7", 3'd3, 16'h2000, 2'd3, 8'h43, 8'h21, 16'h4321, 1'b0);
    chk("R7", {16'd0, mem[8'h08], mem[8'h09]}, 32'h0320);
    @(negedge clk);
    do_ret("R8", 16'h2003);
  endtask

  task automatic t_busy;
    logic [7:0] sp0;
    sp0 = sp_out;
    issue(3'd2, 1'b1, 16'h3000, 2'd2, 3'b010, 8'h44, 8'h00);
    kind = 3'd3; is_call = 1'b0; byte2 = 8'hBE; byte3 = 8'hEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", {23'd0, stk_we, stk_addr}, {23'd0, 1'b1, sp0 + 8'd2});
    chk("R9", {24'd0, stk_wdata}, 32'h30);
    @(negedge clk);
    chk("R9", {15'd0, npc_valid}, 32'd1);
    chk("R9", {16'd0, npc}, 32'h3244);
    @(negedge clk);
    chk("R9", {30'd0, npc_valid, busy}, 32'd0);
    chk("R9", {16'd0, npc}, 32'h3244);
    do_ret("R9", 16'h3002);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 124; i++)
      do_call("R10", 3'd0, 16'h0500, 2'd1, 8'h0, 8'h0, 16'h0501, 1'b1);
    chk("R10", {24'd0, sp_out}, 32'hFF);
    do_call("R10", 3'd3, 16'h6789, 2'd3, 8'h12, 8'h34, 16'h1234, 1'b0);
    chk("R10", {24'd0, sp_out}, 32'h01);
    chk("R10", {16'd0, mem[8'h00], mem[8'h01]}, 32'h8C67);
    @(negedge clk);
    do_ret("R10", 16'h678C);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_seq;
    t_rel;
    t_abs;
    t_long;
    t_idx;
    t_call_ret;
    t_busy;
    t_wrap;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule